// File: doc/BRIEF.md
# Twin Register Bank ALU Datapath

This block is an 8-bit datapath with two separate register banks. Each bank holds four registers. The left bank supplies the first ALU operand and the right bank supplies the second. A read select on each bank picks the register that drives its operand, and the two selects are independent of each other. A two-bit operation code chooses one of four functions: sum, complement of the first operand, bitwise AND, or bitwise OR.

The single ALU result feeds the write port of every register in both banks. When write is enabled, the result is stored into exactly one register. A bank bit and a two-bit index name that register. The result and a carry flag are also presented on registered outputs, so the surrounding logic can watch each operation.

A sequencer outside the block drives one micro-step per clock: both read selects, the operation, and the write target. The sequencer cannot load data directly. After a reset, every value has to be built from the ALU functions, starting with the complement of zero.

Top module: `dbalu_core`

## Requirements
- R1: While `rst` is high at a rising edge, all eight registers, `result` and `carry` become 0. This reset is synchronous.
- R2: `sel_a` picks which left-bank register forms operand A. `sel_b` independently picks which right-bank register forms operand B.
- R3: Op code 2'b00 gives (A + B) mod 256 on `result`. `carry` is the ninth bit of the sum.
- R4: Op code 2'b01 gives ~A. Operand B has no effect, and `carry` is 0.
- R5: Op code 2'b10 gives A & B and op code 2'b11 gives A | B. For both, `carry` is 0.
- R6: `result` and `carry` are registered. They show the operation whose inputs were applied before a rising edge, starting just after that edge.
- R7: When `wr_en` is high, the ALU result is written at the rising edge into register `wr_idx` of the left bank (`wr_bank`=0) or of the right bank (`wr_bank`=1). No other register changes.
- R8: When `wr_en` is low, no register in either bank changes.
- R9: If a register is read and written in the same cycle, the operand uses its old value. The new value is read from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 2 | Left-bank read index (operand A) |
| sel_b | input | 2 | Right-bank read index (operand B) |
| op | input | 2 | Operation: 00 sum, 01 complement A, 10 AND, 11 OR |
| wr_en | input | 1 | Write the ALU result this edge |
| wr_bank | input | 1 | Write target bank: 0 left, 1 right |
| wr_idx | input | 2 | Write target register index |
| result | output | 8 | Registered ALU result |
| carry | output | 1 | Registered carry of the sum, 0 for other operations |

## Verification
Every operation completes in one edge. The ALU result is computed from the register contents before the edge, and it appears on `result` and `carry` just after that same edge, together with the write-back. The bench drives inputs at the falling edge and predicts the outcome from its own copy of the eight registers taken before the update. It samples one time unit after the next rising edge and only then applies the write to its copy, so that same-register read and write keeps the old operand. A write into a register, or the absence of one, only shows when a later operation reads it. The bench therefore checks R7 to R9 through the operands of the following steps.

// File: rtl/dbalu_pkg.sv
package dbalu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_CPL = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/dbalu_bank.sv
module dbalu_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IW-1:0]       widx,
  input  logic [DW-1:0]       wdata,
  input  logic [IW-1:0]       ridx,
  output logic [DW-1:0]       rdata,
  output logic [DEPTH*DW-1:0] contents
);
  logic [DW-1:0] mem [DEPTH];

  // Cleared as a whole on reset, so it maps to flops rather than block RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  // Asynchronous read: the operand sees the pre-edge value (read-before-write).
  assign rdata = mem[ridx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign contents[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/dbalu_alu.sv
module dbalu_alu
  import dbalu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          co
);
  logic [DW:0] sum;
  assign sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    co = 1'b0;
    unique case (op)
      OP_ADD: begin
        y  = sum[DW-1:0];
        co = sum[DW];
      end
      OP_CPL:  y = ~a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dbalu_core.sv
module dbalu_core
  import dbalu_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] sel_a,
  input  logic [IW-1:0] sel_b,
  input  logic [1:0]    op,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [IW-1:0] wr_idx,
  output logic [DW-1:0] result,
  output logic          carry
);
  localparam int NBANK = 2;

  logic [IW-1:0]       rsel  [NBANK];
  logic [DW-1:0]       opnd  [NBANK];
  logic [DEPTH*DW-1:0] cont  [NBANK];
  logic [DW-1:0]       alu_y;
  logic                alu_co;

  assign rsel[0] = sel_a;
  assign rsel[1] = sel_b;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dbalu_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .we       (wr_en && (wr_bank == 1'(b))),
      .widx     (wr_idx),
      .wdata    (alu_y),
      .ridx     (rsel[b]),
      .rdata    (opnd[b]),
      .contents (cont[b])
    );
  end

  dbalu_alu #(.DW(DW)) u_alu (
    .op (alu_op_e'(op)),
    .a  (opnd[0]),
    .b  (opnd[1]),
    .y  (alu_y),
    .co (alu_co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      carry  <= 1'b0;
    end else begin
      result <= alu_y;
      carry  <= alu_co;
    end
  end

  // Named views for the bound checker.
  logic [DW-1:0]       opnd_a, opnd_b;
  logic [DEPTH*DW-1:0] cont_a, cont_b;
  assign opnd_a = opnd[0];
  assign opnd_b = opnd[1];
  assign cont_a = cont[0];
  assign cont_b = cont[1];
endmodule

// File: rtl/dbalu_chk.sv
module dbalu_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          op,
  input logic                wr_en,
  input logic                wr_bank,
  input logic [DW-1:0]       opnd_a,
  input logic [DW-1:0]       opnd_b,
  input logic [DEPTH*DW-1:0] cont_a,
  input logic [DEPTH*DW-1:0] cont_b,
  input logic [DW-1:0]       result,
  input logic                carry
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0 && !carry && cont_a == '0 && cont_b == '0));

  // R3
  sum_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'b00) |->
      ({carry, result} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

  // R4
  cpl_only_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'b01) |-> (result == ~$past(opnd_a) && !carry));

  // R5
  and_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'b10) |-> (result == ($past(opnd_a) & $past(opnd_b)) && !carry));

  // R5
  or_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'b11) |-> (result == ($past(opnd_a) | $past(opnd_b)) && !carry));

  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cont_a) && $stable(cont_b)));

  // R7
  left_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bank) |=> $stable(cont_b));

  // R7
  right_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bank) |=> $stable(cont_a));
endmodule

bind dbalu_core dbalu_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op      (op),
  .wr_en   (wr_en),
  .wr_bank (wr_bank),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .cont_a  (cont_a),
  .cont_b  (cont_b),
  .result  (result),
  .carry   (carry)
);

// File: tb/dbalu_core_tb.sv
module dbalu_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_a = '0, sel_b = '0, op = '0, wr_idx = '0;
  logic       wr_en = 1'b0, wr_bank = 1'b0;
  logic [7:0] result;
  logic       carry;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [7:0] mdl [2][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbalu_core dut_i (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .op(op),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .result(result), .carry(carry)
  );

  function automatic logic [8:0] ref_alu(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b);
    case (o)
      2'b00:   return {1'b0, a} + {1'b0, b};
      2'b01:   return {1'b0, ~a};
      2'b10:   return {1'b0, a & b};
      default: return {1'b0, a | b};
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare(input logic [8:0] act, input logic [8:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: carry/result actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] sa, input logic [1:0] sb, input logic [1:0] o,
                      input logic we, input logic wb, input logic [1:0] wi, input string tag);
    logic [8:0] exp;
    @(negedge clk);
    sel_a = sa; sel_b = sb; op = o; wr_en = we; wr_bank = wb; wr_idx = wi;
    exp = ref_alu(o, mdl[0][sa], mdl[1][sb]);
    @(posedge clk);
    #1;
    compare({carry, result}, exp, tag);
    if (we) mdl[wb][wi] = exp[7:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    compare({carry, result}, 9'h000, "R1");
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 4; r++) mdl[b][r] = 8'h00;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd24681));
    do_reset();
    // R1: every register reads back as zero
    for (int i = 0; i < 4; i++) step(2'(i), 2'(i), 2'b11, 1'b0, 1'b0, 2'd0, "R1");
    // R8: complement without write leaves left register 0 at zero
    step(2'd0, 2'd0, 2'b01, 1'b0, 1'b0, 2'd0, "R8");
    step(2'd0, 2'd0, 2'b01, 1'b0, 1'b0, 2'd0, "R8");
    // R7: write FF into right register 1 only
    step(2'd0, 2'd0, 2'b01, 1'b1, 1'b1, 2'd1, "R7");
    for (int i = 0; i < 4; i++) step(2'd0, 2'(i), 2'b11, 1'b0, 1'b0, 2'd0, "R7");
    // R7: left bank untouched by the right-bank write
    for (int i = 0; i < 4; i++) step(2'(i), 2'd1, 2'b01, 1'b0, 1'b0, 2'd0, "R7");
    // R9: read and write left register 2 together: old then new
    step(2'd2, 2'd0, 2'b01, 1'b1, 1'b0, 2'd2, "R9");
    step(2'd2, 2'd0, 2'b01, 1'b0, 1'b0, 2'd0, "R9");
    // R3: FF + FF wraps with carry
    step(2'd2, 2'd1, 2'b00, 1'b1, 1'b0, 2'd3, "R3");
    step(2'd3, 2'd1, 2'b00, 1'b0, 1'b0, 2'd0, "R3");
    // R4: right operand has no influence
    step(2'd3, 2'd0, 2'b01, 1'b0, 1'b0, 2'd0, "R4");
    step(2'd3, 2'd1, 2'b01, 1'b0, 1'b0, 2'd0, "R4");
    // R5: AND and OR on distinct patterns
    step(2'd3, 2'd1, 2'b10, 1'b0, 1'b0, 2'd0, "R5");
    step(2'd3, 2'd0, 2'b11, 1'b0, 1'b0, 2'd0, "R5");
    // R2, R6: random mix of selects, ops and write targets
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] o;
      o = 2'($urandom);
      step(2'($urandom), 2'($urandom), o, 1'($urandom), 1'($urandom), 2'($urandom),
           (n % 2) ? op_tag(o) : "R2/R6");
    end
    // R1: reset in the middle of a run
    do_reset();
    for (int i = 0; i < 4; i++) step(2'(i), 2'(3 - i), 2'b11, 1'b0, 1'b0, 2'd0, "R1");
    for (int n = 0; n < 500; n++) begin
      logic [1:0] o;
      o = 2'($urandom);
      step(2'($urandom), 2'($urandom), o, 1'($urandom), 1'($urandom), 2'($urandom), op_tag(o));
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule